// File: doc/BRIEF.md
# Dirty Line Write-Back Buffer

This block sits between a cache controller and the external memory port. When the controller evicts a line whose modified flag is set, it hands the whole line and its address to this buffer in a single cycle. The controller can then start its refill read at once, without waiting for the victim to reach memory first. Lines that were never modified are not taken; the controller simply drops them.

Once it holds a line, the buffer waits. It stays off the memory port until the controller reports that its refill has finished and the port is free. It then writes the line out as a burst of word writes over a request/acknowledge handshake. The lowest-addressed word goes first, and the next word is offered after each acknowledge. While it holds or drains a line it raises a busy flag. A second eviction offered during that time is refused with a stall indication, and the held line is left as it is.

Top module: `wbb_line_buffer`

## Requirements
- R1: After reset, `busy`, `mem_req` and `cap_stall` are all 0.
- R2: With `busy` low, a cycle with `cap_req`=1 and `cap_dirty`=1 captures `cap_addr` and `cap_line`, and `busy` reads 1 from the next cycle on.
- R3: With `busy` low, a cycle with `cap_req`=1 and `cap_dirty`=0 captures nothing: `busy` and `mem_req` stay 0.
- R4: After a capture, `mem_req` stays 0 until `fill_done` has been seen high on a clock edge. A rising `mem_req` is always preceded by `fill_done` high in the cycle before.
- R5: On the edge where `fill_done` is seen while a line is held, the drain starts. In the next cycle `mem_req` is 1, and it offers word 0 at the line base address, which is `cap_addr` with its low 4 bits forced to 0.
- R6: Word k (k = 0..3) is `cap_line[32*k +: 32]` and is written to the base address plus 4*k. The words go out in ascending k. The index advances by one on each edge with `mem_req`=1 and `mem_ack`=1. Without an acknowledge, the address and data are held.
- R7: `busy` stays 1 from the capture until the fourth acknowledge. In the cycle after that acknowledge, `busy` and `mem_req` are both 0.
- R8: `cap_stall` equals `cap_req` while `busy` is 1, and is 0 while `busy` is 0. A request refused this way changes neither the held address nor the held data.
- R9: `fill_done` while no line is held, or while a drain is running, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_req | input | 1 | Controller offers an evicted line this cycle |
| cap_dirty | input | 1 | Modified flag of the offered line |
| cap_addr | input | 32 | Address of the offered line (low 4 bits ignored) |
| cap_line | input | 128 | Offered line, word k in bits 32k+31..32k |
| cap_stall | output | 1 | Offer refused because a line is still held |
| fill_done | input | 1 | Controller's refill has finished and the memory port is free |
| busy | output | 1 | A line is held or being drained |
| mem_req | output | 1 | Word write request to memory |
| mem_addr | output | 32 | Byte address of the current word |
| mem_wdata | output | 32 | Data of the current word |
| mem_ack | input | 1 | Memory accepts the current word |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high. They also assume that the controller pulses `fill_done` to end a refill it started after a capture. The buffer is built to ignore stray pulses, but the index-step property is written on the acknowledged-request case only. The random stimulus derives each cycle's acknowledge from the request level it has just observed, so it never acknowledges an idle port. It fires `fill_done`, offers and modified flags freely in every phase, which also tests that pulses outside the holding phase are ignored.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_HOLD  = 2'd1,
    WB_DRAIN = 2'd2
  } wb_phase_e;

endpackage

// File: rtl/wbb_rst_sync.sv
module wbb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/wbb_ctrl.sv
module wbb_ctrl #(
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_req,
  input  logic             cap_dirty,
  input  logic             fill_done,
  input  logic             mem_ack,
  output logic             load_en,
  output logic             busy,
  output logic             mem_req,
  output logic [IDX_W-1:0] word_idx
);
  import wbb_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  wb_phase_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load_en = 1'b0;
    case (state_q)
      WB_IDLE: begin
        if (cap_req && cap_dirty) begin
          load_en = 1'b1;
          state_d = WB_HOLD;
        end
      end
      WB_HOLD: begin
        if (fill_done) begin
          state_d = WB_DRAIN;
          idx_d   = '0;
        end
      end
      WB_DRAIN: begin
        if (mem_ack) begin
          if (idx_q == LAST_IDX) begin
            state_d = WB_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: begin
        state_d = WB_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WB_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy     = (state_q != WB_IDLE);
  assign mem_req  = (state_q == WB_DRAIN);
  assign word_idx = idx_q;

  // R2: a modified victim offered to an empty buffer is taken
  a_r2_dirty_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cap_req && cap_dirty) |=> busy);

  // R3: an unmodified victim is not taken
  a_r3_clean_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cap_req && !cap_dirty) |=> !busy);

  // R4: the drain only begins after the refill finished
  a_r4_drain_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(fill_done));

  // R6: one word step per acknowledge
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && idx_q != LAST_IDX) |=> (word_idx == $past(idx_q) + IDX_W'(1)));

  // R7: busy only drops after an acknowledged word
  a_r7_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_ack && mem_req));

endmodule

// File: rtl/wbb_store.sv
module wbb_store #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W    = $clog2(WORDS),
  localparam int BYTE_W   = $clog2(WORD_W / 8),
  localparam int LINE_OFF = IDX_W + BYTE_W,
  localparam int LINE_W   = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LINE_W-1:0] cap_line,
  input  logic [IDX_W-1:0]  word_idx,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  logic [ADDR_W-LINE_OFF-1:0] base_q, base_d;
  logic [LINE_W-1:0]          line_q, line_d;
  logic [WORD_W-1:0]          words [WORDS];
  logic                       unused_low_addr;

  assign unused_low_addr = ^cap_addr[LINE_OFF-1:0];

  // load path with explicit enable
  always_comb begin
    base_d = base_q;
    line_d = line_q;
    if (load_en) begin
      base_d = cap_addr[ADDR_W-1:LINE_OFF];
      line_d = cap_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      line_q <= '0;
    end else begin
      base_q <= base_d;
      line_q <= line_d;
    end
  end

  // split the held line into words, lowest word at the lowest address
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign words[k] = line_q[k*WORD_W +: WORD_W];
  end

  assign mem_wdata = words[word_idx];
  assign mem_addr  = {base_q, word_idx, {BYTE_W{1'b0}}};

endmodule

// File: rtl/wbb_line_buffer.sv
module wbb_line_buffer #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W    = $clog2(WORDS),
  localparam int LINE_OFF = IDX_W + $clog2(WORD_W / 8),
  localparam int LINE_W   = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              cap_dirty,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [LINE_W-1:0] cap_line,
  output logic              cap_stall,
  input  logic              fill_done,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack
);

  logic             rst_int_n;
  logic             load_en;
  logic [IDX_W-1:0] word_idx;

  wbb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  wbb_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cap_req   (cap_req),
    .cap_dirty (cap_dirty),
    .fill_done (fill_done),
    .mem_ack   (mem_ack),
    .load_en   (load_en),
    .busy      (busy),
    .mem_req   (mem_req),
    .word_idx  (word_idx)
  );

  wbb_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (load_en),
    .cap_addr  (cap_addr),
    .cap_line  (cap_line),
    .word_idx  (word_idx),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign cap_stall = cap_req & busy;

  // R6: an unacknowledged word is held
  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R8: a refused offer leaves the held line address alone
  a_r8_stall_keeps_line: assert property (@(posedge clk) disable iff (!rst_int_n)
    cap_stall |=> $stable(mem_addr[ADDR_W-1:LINE_OFF]));

  // R1: nothing is requested while held in reset
  always_comb begin
    if (!rst_int_n) begin
      a_r1_reset_quiet: assert (!mem_req && !busy);
    end
  end

endmodule

// File: tb/sim_wbb_line_buffer.sv
module sim_wbb_line_buffer;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cap_req, cap_dirty, fill_done, mem_ack;
  logic [31:0]  cap_addr;
  logic [127:0] cap_line;
  logic         cap_stall, busy, mem_req;
  logic [31:0]  mem_addr, mem_wdata;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference model state
  int           m_phase = 0;   // 0 empty, 1 holding, 2 draining
  int           m_idx = 0;
  logic [31:0]  m_base = '0;
  logic [127:0] m_line = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbb_line_buffer u0 (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_dirty(cap_dirty),
    .cap_addr(cap_addr), .cap_line(cap_line), .cap_stall(cap_stall),
    .fill_done(fill_done), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int k);
    return {base[31:4], 4'b0000} + 32'(4 * k);
  endfunction

  function automatic logic [31:0] exp_word(input logic [127:0] line, input int k);
    return line[32*k +: 32];
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, check stall, clock, advance model, check outputs
  task automatic cycle(input logic cr, input logic cd, input logic [31:0] ca,
                       input logic [127:0] cl, input logic fd, input logic ack_en);
    logic ack;
    ack       = ack_en & mem_req;
    cap_req   = cr;
    cap_dirty = cd;
    cap_addr  = ca;
    cap_line  = cl;
    fill_done = fd;
    mem_ack   = ack;
    #1;
    chk("R8 cap_stall", 128'(cap_stall), 128'(cr && m_phase != 0));
    @(posedge clk);
    case (m_phase)
      0: if (cr && cd) begin m_phase = 1; m_base = ca; m_line = cl; end
      1: if (fd) begin m_phase = 2; m_idx = 0; end
      default: if (ack) begin
        if (m_idx == 3) m_phase = 0;
        else m_idx = m_idx + 1;
      end
    endcase
    #1;
    chk("R7 busy", 128'(busy), 128'(m_phase != 0));
    chk("R4 mem_req", 128'(mem_req), 128'(m_phase == 2));
    if (m_phase == 2) begin
      chk("R6 mem_addr", 128'(mem_addr), 128'(exp_addr(m_base, m_idx)));
      chk("R6 mem_wdata", 128'(mem_wdata), 128'(exp_word(m_line, m_idx)));
    end
  endtask

  localparam logic [127:0] LINE_A = 128'h4444_0003_3333_0002_2222_0001_1111_0000;
  localparam logic [127:0] LINE_B = 128'hdead_beef_cafe_f00d_0bad_c0de_feed_face;

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cap_req = 0; cap_dirty = 0; fill_done = 0; mem_ack = 0;
    cap_addr = '0; cap_line = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 busy after reset", 128'(busy), 128'(0));
    chk("R1 mem_req after reset", 128'(mem_req), 128'(0));
    chk("R1 cap_stall after reset", 128'(cap_stall), 128'(0));

    // R9: stray fill_done while empty
    cycle(0, 0, '0, '0, 1, 0);
    chk("R9 idle fill_done ignored", 128'({busy, mem_req}), 128'(0));
    // R3: clean victim bypasses the buffer
    cycle(1, 0, 32'h1000_0040, LINE_B, 0, 0);
    chk("R3 clean not captured", 128'({busy, mem_req}), 128'(0));
    // R2: dirty victim captured (unaligned address, low bits dropped)
    cycle(1, 1, 32'h8000_123c, LINE_A, 0, 0);
    chk("R2 busy after capture", 128'(busy), 128'(1));
    // R8: offer while holding is stalled and ignored
    cycle(1, 1, 32'h0000_0f00, LINE_B, 0, 0);
    // R4: no drain while the refill is still running
    for (int i = 0; i < 5; i++) cycle(0, 0, '0, '0, 0, 1);
    chk("R4 no request before fill_done", 128'(mem_req), 128'(0));
    // R5: drain begins with word 0 at the aligned base
    cycle(0, 0, '0, '0, 1, 0);
    chk("R5 first addr", 128'(mem_addr), 128'(32'h8000_1230));
    chk("R5 first word", 128'(mem_wdata), 128'(32'h1111_0000));
    // R6: gaps without acknowledge hold the word; R9 fill_done in drain ignored
    cycle(0, 0, '0, '0, 1, 0);
    cycle(0, 0, '0, '0, 0, 1);
    chk("R6 second addr", 128'(mem_addr), 128'(32'h8000_1234));
    chk("R6 second word", 128'(mem_wdata), 128'(32'h2222_0001));
    cycle(0, 0, '0, '0, 0, 1);
    cycle(0, 0, '0, '0, 0, 0);
    cycle(1, 1, 32'h0000_0f00, LINE_B, 0, 1);
    chk("R6 fourth addr", 128'(mem_addr), 128'(32'h8000_123c));
    chk("R8 held word after stall", 128'(mem_wdata), 128'(32'h4444_0003));
    // R7: last acknowledge ends the drain
    cycle(0, 0, '0, '0, 0, 1);
    chk("R7 busy after last ack", 128'({busy, mem_req}), 128'(0));

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [127:0] rl;
      rl = {$urandom, $urandom, $urandom, $urandom};
      cycle(($urandom % 4) == 0, ($urandom % 2) == 0, $urandom, rl,
            ($urandom % 8) == 0, ($urandom % 2) == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule